// File: doc/BRIEF.md
# Bidirectional Six-Mode Vector Shifter

This block moves the bits of a data word by a signed distance under one of six operations: zero-fill moves toward either end, two fill-by-copy moves (the lowest bit copied into the vacated low end on a left move, the top bit copied into the vacated high end on a right move), and rotation in either direction. The distance is a two's-complement count. A negative count does not fail: it runs the partner operation that moves the other way, by the size of the count.

The result always has the same width as the input. A parameter chooses whether the result leaves through a register, with one cycle of latency and an asynchronous active-low clear, or straight from the combinational logic. Counts whose size reaches or passes the word width flush every bit position with fill. Rotations use the count modulo the width.

Top module: `vec_shifter`

## Requirements
- R1: Op code 0 moves left and op code 1 moves right by the count, and zeros fill the vacated positions (4-bit 1011: left by 1 gives 0110, right by 3 gives 0001).
- R2: Op code 2 moves left and copies the input's bit 0 into every vacated low position (1011: by 1 gives 0111, by 3 gives 1111).
- R3: Op code 3 moves right and copies the input's top bit into every vacated high position (1011: by 1 gives 1101, by 3 gives 1111).
- R4: Op code 4 rotates left and op code 5 rotates right. No bit is lost, and the count is taken modulo WIDTH (1011: left by 1 gives 0111, left by 3 gives 1101, right by 1 gives 1101, left by 5 gives 0111).
- R5: A negative count on op codes 0 to 5 runs the opposite-direction partner (0 with 1, 2 with 3, 4 with 5) by the size of the count.
- R6: For op codes 0 to 3, a count whose size is WIDTH or more makes every output bit equal to the fill value of that operation.
- R7: A count of 0 returns the input unchanged for every op code.
- R8: Op codes 6 and 7 return the input unchanged for any count.
- R9: With REG_OUT=1, the result of the inputs present at a rising clock edge appears after that edge, and an active-low reset clears the output to zero. With REG_OUT=0, the output follows the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register (unused when REG_OUT=0) |
| rst_n | input | 1 | Asynchronous active-low clear of the output register |
| data_in | input | WIDTH | Word to be moved |
| shift_amt | input | $clog2(WIDTH)+2 | Signed two's-complement distance |
| op | input | 3 | Operation code |
| data_out | output | WIDTH | Result, same width as data_in |

## Verification
The bound checker tests on every cycle the properties that hold whatever the data is: zero-count and spare-code passthrough, flushing to zero or to copies of the fill bit on oversized counts, the unchanged number of ones under rotation, and clearing by reset. The exact bit placement of each operation, the swap of partner operations under negative counts, and the wrap of rotation counts can only be shown by the bench. It compares every op code at every count from -WIDTH to +WIDTH against an independent bit-index model, and it also checks the 4-bit example values on a combinational instance.

// File: rtl/vec_shifter.sv
module vec_shifter #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = $clog2(WIDTH) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [WIDTH-1:0]     data_in,
  input  logic signed [CW-1:0] shift_amt,
  input  logic [2:0]           op,
  output logic [WIDTH-1:0]     data_out
);

  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};
  localparam logic [CW-1:0]    WVAL = CW'(WIDTH);

  logic             neg;
  logic [CW-1:0]    mag;
  logic [CW-1:0]    rot;
  logic [2:0]       eff;
  logic [WIDTH-1:0] shl, shr, low_fill, high_fill, res;

  assign neg       = shift_amt[CW-1];
  assign mag       = neg ? CW'(-shift_amt) : CW'(shift_amt);
  assign rot       = mag % WVAL;
  assign eff       = (neg && op < 3'd6) ? {op[2:1], ~op[0]} : op;
  assign shl       = data_in << mag;
  assign shr       = data_in >> mag;
  assign low_fill  = ~(ONES << mag);
  assign high_fill = ~(ONES >> mag);

  always_comb begin
    case (eff)
      3'd0:    res = shl;
      3'd1:    res = shr;
      3'd2:    res = shl | (data_in[0] ? low_fill : '0);
      3'd3:    res = shr | (data_in[WIDTH-1] ? high_fill : '0);
      3'd4:    res = (data_in << rot) | (data_in >> (WIDTH - int'(rot)));
      3'd5:    res = (data_in >> rot) | (data_in << (WIDTH - int'(rot)));
      default: res = data_in;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_out <= '0;
        else        data_out <= res;
      end
    end else begin : g_comb
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign data_out = res;
    end
  endgenerate

endmodule

// File: rtl/vec_shifter_chk.sv
module vec_shifter_chk #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int CW     = $clog2(WIDTH) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [WIDTH-1:0]     data_in,
  input logic signed [CW-1:0] shift_amt,
  input logic [2:0]           op,
  input logic [WIDTH-1:0]     data_out
);

  logic [WIDTH-1:0] d_s;
  logic [CW-1:0]    c_s;
  logic [2:0]       o_s;
  logic             vld;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_s <= '0; c_s <= '0; o_s <= '0; vld <= 1'b0;
        end else begin
          d_s <= data_in; c_s <= shift_amt; o_s <= op; vld <= 1'b1;
        end
      end
      assert_reset_clear_R9: assert property (@(posedge clk)
        !rst_n |=> data_out == '0);
    end else begin : g_now
      assign d_s = data_in;
      assign c_s = shift_amt;
      assign o_s = op;
      assign vld = 1'b1;
    end
  endgenerate

  logic          c_neg;
  logic [CW-1:0] c_abs;
  logic          huge;
  assign c_neg = c_s[CW-1];
  assign c_abs = c_neg ? CW'(-c_s) : c_s;
  assign huge  = int'(c_abs) >= WIDTH;

  assert_zero_count_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vld && c_s == '0 |-> data_out == d_s);

  assert_spare_op_passthru_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vld && o_s >= 3'd6 |-> data_out == d_s);

  assert_logical_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld && o_s <= 3'd1 && huge |-> data_out == '0);

  assert_arith_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vld && (o_s == 3'd2 || o_s == 3'd3) && huge |->
      data_out == {WIDTH{((o_s == 3'd3) ^ c_neg) ? d_s[WIDTH-1] : d_s[0]}});

  assert_rotate_keeps_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vld && (o_s == 3'd4 || o_s == 3'd5) |-> $countones(data_out) == $countones(d_s));

  assert_logical_no_new_ones_R1: assert property (@(posedge clk) disable iff (!rst_n)
    vld && o_s <= 3'd1 |-> $countones(data_out) <= $countones(d_s));

endmodule

bind vec_shifter vec_shifter_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_in(data_in), .shift_amt(shift_amt),
  .op(op), .data_out(data_out));

// File: tb/sim_vec_shifter.sv
module sim_vec_shifter;
  localparam int W   = 8;
  localparam int CW  = $clog2(W) + 2;
  localparam int W4  = 4;
  localparam int CW4 = $clog2(W4) + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0]         din = '0;
  logic signed [CW-1:0] cnt = '0;
  logic [2:0]           opc = '0;
  logic [W-1:0]         dout;

  logic [W4-1:0]         din4 = '0;
  logic signed [CW4-1:0] cnt4 = '0;
  logic [2:0]            opc4 = '0;
  logic [W4-1:0]         dout4;

  vec_shifter #(.WIDTH(W), .REG_OUT(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .data_in(din), .shift_amt(cnt), .op(opc), .data_out(dout));

  vec_shifter #(.WIDTH(W4), .REG_OUT(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .data_in(din4), .shift_amt(cnt4), .op(opc4), .data_out(dout4));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  function automatic logic [W-1:0] model(logic [W-1:0] d, int c, int o);
    logic [W-1:0] r;
    int m = (c < 0) ? -c : c;
    int e = (c < 0 && o < 6) ? (o ^ 1) : o;
    for (int i = 0; i < W; i++) begin
      case (e)
        0: r[i] = (i - m >= 0) ? d[i-m] : 1'b0;
        1: r[i] = (i + m < W)  ? d[i+m] : 1'b0;
        2: r[i] = (i - m >= 0) ? d[i-m] : d[0];
        3: r[i] = (i + m < W)  ? d[i+m] : d[W-1];
        4: r[i] = d[(((i - m) % W) + W) % W];
        5: r[i] = d[(i + m) % W];
        default: r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string tag_for(int c, int o);
    int m = (c < 0) ? -c : c;
    if (c == 0) return "R7";
    if (o >= 6) return "R8";
    if (c < 0) return "R5";
    if (m >= W && o < 4) return "R6";
    if (o == 2) return "R2";
    if (o == 3) return "R3";
    if (o >= 4) return "R4";
    return "R1";
  endfunction

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] d, int c, int o);
    @(negedge clk);
    din = d; cnt = CW'(c); opc = 3'(o);
    exp_q.push_back(model(d, c, o));
    tag_q.push_back(tag_for(c, o));
  endtask

  task automatic ex4(string tag, logic [W4-1:0] d, int c, int o, logic [W4-1:0] exp);
    din4 = d; cnt4 = CW4'(c); opc4 = 3'(o);
    #1;
    check(tag, {{(W-W4){1'b0}}, dout4}, {{(W-W4){1'b0}}, exp});
  endtask

  always begin
    @(posedge clk);
    #2;
    if (mon_on && exp_q.size() > 0) begin
      automatic logic [W-1:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(t, dout, e);
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] pats[8];
    pats = '{8'hB3, 8'h01, 8'h80, 8'hFF, 8'h00, 8'h5A, 8'hC6, 8'h7E};
    din = 8'hA5; cnt = CW'(3); opc = 3'd4;
    repeat (3) @(posedge clk);
    #2;
    check("R9 reset", dout, '0);

    // R1..R6 on the 4-bit combinational copy (R9 REG_OUT=0)
    ex4("R1", 4'b1011,  1, 0, 4'b0110);
    ex4("R1", 4'b1011,  3, 1, 4'b0001);
    ex4("R2", 4'b1011,  1, 2, 4'b0111);
    ex4("R2", 4'b1011,  3, 2, 4'b1111);
    ex4("R3", 4'b1011,  1, 3, 4'b1101);
    ex4("R3", 4'b1011,  3, 3, 4'b1111);
    ex4("R4", 4'b1011,  1, 4, 4'b0111);
    ex4("R4", 4'b1011,  3, 4, 4'b1101);
    ex4("R4", 4'b1011,  1, 5, 4'b1101);
    ex4("R4", 4'b1011,  5, 4, 4'b0111);
    ex4("R5", 4'b1011, -3, 0, 4'b0001);
    ex4("R5", 4'b1011, -3, 4, 4'b0111);
    ex4("R5", 4'b1011, -3, 3, 4'b1111);
    ex4("R6", 4'b1011,  4, 0, 4'b0000);
    ex4("R6", 4'b1011,  4, 2, 4'b1111);
    ex4("R8", 4'b1011,  2, 6, 4'b1011);

    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;
    for (int p = 0; p < 8; p++)
      for (int o = 0; o < 8; o++)
        for (int c = -W; c <= W; c++)
          drive(pats[p], c, o);
    repeat (3) @(posedge clk);

    // R9: reset mid-run clears the registered output
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R9 async clear", dout, '0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(8'h96, -2, 5);
    repeat (3) @(posedge clk);
    #3;
    if (exp_q.size() != 0) check("R9 drain", W'(exp_q.size()), '0);
    done = 1'b1;
    finish_run();
  end
endmodule